// File: doc/BRIEF.md
# DRAM Power-Up and Self-Refresh Sequencer

This block owns the row strobe, the column strobes and the write strobe of an asynchronous DRAM whenever the memory is not doing ordinary reads and writes. After reset it keeps every strobe high for a programmable pause. It then issues a fixed number of CAS-before-RAS wake-up cycles and raises `ready`, which hands the strobes to the access controller.

While `ready` is high, a host may raise `sleep_req`. The sequencer then takes the strobes back and drops the column strobes. It drops the row strobe and keeps it low for a programmable hold time, then raises `sleep_ack`, and the memory refreshes itself. When the host withdraws the request, the row strobe goes high for at least the precharge time. Because the block cannot assume the controller refreshes in a distributed way, it then runs a CAS-before-RAS burst over every row before raising `ready` again.

All delays are counted in clock cycles and set by parameters. With the 200 MHz defaults these are a 200 µs pause, a 100 µs sleep hold, a 1,024-row exit burst and a 30 ns precharge.

Top module: `dram_lifecycle_seq`

## Requirements
- R1: While `rst_n` is low and on the first edge after it, `ready`=0, `sleep_ack`=0, `own`=1, `ras_n`=1, every bit of `cas_n`=1 and `we_n`=1. A reset at any point returns the block to this state and restarts the power-up sequence.
- R2: After reset is released, `ras_n` stays high for at least `PAUSE_CYC` cycles before its first fall, and `cas_n` stays all ones during the pause.
- R3: After the pause, exactly `WAKE_CYC` refresh cycles are issued, and then `ready` rises. At every falling edge of `ras_n` caused by the block, all `cas_n` bits are already 0 (column strobe before row strobe).
- R4: A `sleep_req` seen while `ready` is 0 during power-up has no effect. No `sleep_ack` appears, and the wake-up count and timing stay unchanged, provided the request is withdrawn before `ready` rises.
- R5: When `sleep_req` is sampled high while `ready`=1, self refresh starts. The column strobes fall for `CSR_CYC` cycles, then `ras_n` falls. `sleep_ack` rises after `ras_n` has been low for exactly `HOLD_CYC` cycles, and stays high only while `ras_n`=0 and `cas_n`=0.
- R6: `ready` falls on the first clock edge that samples an accepted `sleep_req`. `ready` and `sleep_ack` are never high together, and `own` is always the inverse of `ready`.
- R7: `sleep_ack` falls only on the edge after `sleep_req` is sampled low. After exit, `ras_n` stays high for at least `RP_CYC` cycles before the next fall.
- R8: After the exit precharge, exactly `BURST_CYC` refresh cycles are issued, and then `ready` rises again.
- R9: If `sleep_req` is withdrawn before `sleep_ack`, the row-strobe hold still lasts `HOLD_CYC` cycles. No acknowledge is given, and the exit precharge and full burst follow.
- R10: `we_n` is 1 at all times.
- R11: Every refresh cycle keeps `ras_n` low for exactly `RAS_CYC` cycles, with `RP_CYC` cycles of precharge between cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_req | input | 1 | Host request to enter self refresh (level) |
| sleep_ack | output | 1 | Memory is in self refresh |
| ready | output | 1 | Access controller may use the memory |
| own | output | 1 | Strobes below are driven by this block |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | CAS_W | Column strobes, one per byte lane, active low |
| we_n | output | 1 | Write strobe, held high |

## Verification
Every output is decoded from registered state, so each result shows up one edge after the input that causes it. `ready` falls one cycle after a request is accepted. `sleep_ack` appears on the cycle after the hold count runs out, which is `HOLD_CYC`+1 sampled low cycles into the hold. The first burst fall arrives `RP_CYC`+`CSR_CYC`+1 cycles after the exit rise. The bench drives inputs on the falling edge and samples one time unit after it. Pulse widths and precharge gaps are measured as counts of sampled cycles rather than absolute times, so each check lands on the cycle where the registered change becomes visible. Refresh counts are taken as row-strobe falls between the request and the return of `ready`.

// File: rtl/dls_pkg.sv
// Shared types of the DRAM power-up and self-refresh sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package dls_pkg;

    // Lifecycle states of the top-level controller
    typedef enum logic [3:0] {
        ST_INIT,
        ST_PAUSE,
        ST_WAKE,
        ST_READY,
        ST_SR_SETUP,
        ST_SR_HOLD,
        ST_SR_STAY,
        ST_SR_EXIT,
        ST_BURST
    } life_state_t;

    // Phases of one CAS-before-RAS refresh cycle
    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_LOW,
        PH_PRE
    } cbr_phase_t;

endpackage

// File: rtl/dls_timer.sv
// Loadable down-counter used for every fixed wait of the sequencer.
// What it does: on load takes load_val, then counts down to zero and stays.
// Assumes: the wait lasts load_val+1 cycles counted from the loading edge.
module dls_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    // Count down toward zero, reload on request
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    // Counter never moves upward without a load
    p_timer_monotonic_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load) && $past(rst_n) |-> cnt <= $past(cnt));
endmodule

// File: rtl/dls_event_counter.sv
// Counts refresh cycles completed within one wake-up or exit burst.
// Assumes: clr and inc are never both high when inc should be counted.
module dls_event_counter #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    // Clear at the start of a sequence, advance on each completed cycle
    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (clr) count <= '0;
        else if (inc) count <= count + 1'b1;
    end
endmodule

// File: rtl/dls_cbr_gen.sv
// Generates back-to-back CAS-before-RAS refresh cycles while run is high.
// One cycle: column strobe low for CSR cycles, row strobe low for RAS cycles
// (column strobe kept low for the first CHR of them), then RP cycles of
// precharge with both high. done pulses in the last precharge cycle.
// Assumes: CSR_CYC, RAS_CYC, RP_CYC >= 1 and CHR_CYC < RAS_CYC.
module dls_cbr_gen
    import dls_pkg::*;
#(
    parameter int CSR_CYC = 1,
    parameter int CHR_CYC = 2,
    parameter int RAS_CYC = 10,
    parameter int RP_CYC  = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic ras_n,
    output logic cas_n,
    output logic done
);
    localparam int PMAX = (RAS_CYC > RP_CYC) ? RAS_CYC : RP_CYC;
    localparam int LMAX = (PMAX > CSR_CYC) ? PMAX : CSR_CYC;
    localparam int W    = $clog2(LMAX + 1);

    cbr_phase_t   phase;
    logic [W-1:0] cnt;

    // Walk the phases of one refresh cycle, looping while run stays high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (run) begin
                    phase <= PH_SETUP;
                    cnt   <= W'(CSR_CYC - 1);
                end
                PH_SETUP: if (cnt == '0) begin
                    phase <= PH_LOW;
                    cnt   <= W'(RAS_CYC - 1);
                end else cnt <= cnt - 1'b1;
                PH_LOW: if (cnt == '0) begin
                    phase <= PH_PRE;
                    cnt   <= W'(RP_CYC - 1);
                end else cnt <= cnt - 1'b1;
                PH_PRE: if (cnt == '0) begin
                    if (run) begin
                        phase <= PH_SETUP;
                        cnt   <= W'(CSR_CYC - 1);
                    end else begin
                        phase <= PH_IDLE;
                    end
                end else cnt <= cnt - 1'b1;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign ras_n = (phase != PH_LOW);
    assign cas_n = !((phase == PH_SETUP) ||
                     ((phase == PH_LOW) && (cnt > W'(RAS_CYC - 1 - CHR_CYC))));
    assign done  = (phase == PH_PRE) && (cnt == '0);

    // Column strobe already low whenever the row strobe falls
    p_cas_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> !cas_n);
    // A cycle only ends from precharge with the row strobe high
    p_done_in_precharge_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ras_n && cas_n);
endmodule

// File: rtl/dram_lifecycle_seq.sv
// Top of the DRAM power-up and self-refresh sequencer.
// What it does: pause after reset, wake-up refresh cycles, hand-over via
// ready; on sleep_req enters self refresh, acknowledges after a hold, and on
// withdrawal precharges and refreshes every row before handing back.
// Assumes: the access controller drives the strobes only while ready=1;
// all timings are given as cycle counts of clk.
module dram_lifecycle_seq
    import dls_pkg::*;
#(
    parameter int CAS_W     = 2,
    parameter int PAUSE_CYC = 40000,
    parameter int WAKE_CYC  = 8,
    parameter int HOLD_CYC  = 20000,
    parameter int BURST_CYC = 1024,
    parameter int CSR_CYC   = 1,
    parameter int CHR_CYC   = 2,
    parameter int RAS_CYC   = 10,
    parameter int RP_CYC    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_req,
    output logic             sleep_ack,
    output logic             ready,
    output logic             own,
    output logic             ras_n,
    output logic [CAS_W-1:0] cas_n,
    output logic             we_n
);
    localparam int T_A  = (PAUSE_CYC > HOLD_CYC) ? PAUSE_CYC : HOLD_CYC;
    localparam int T_B  = (RP_CYC > CSR_CYC) ? RP_CYC : CSR_CYC;
    localparam int TMAX = (T_A > T_B) ? T_A : T_B;
    localparam int TW   = $clog2(TMAX + 1);
    localparam int CMAX = (WAKE_CYC > BURST_CYC) ? WAKE_CYC : BURST_CYC;
    localparam int CW   = $clog2(CMAX + 1);

    life_state_t   state, state_nx;
    logic          tmr_load, tmr_exp;
    logic [TW-1:0] tmr_val;
    logic          cnt_clr, cnt_last;
    logic [CW-1:0] cbr_cnt, cbr_target;
    logic          cbr_run, cbr_done, cbr_ras_n, cbr_cas_n;
    logic          sr_ras_low, sr_cas_low, cas_line;

    dls_timer #(.W(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load),
        .load_val(tmr_val), .expired(tmr_exp)
    );

    dls_event_counter #(.W(CW)) u_count (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr),
        .inc(cbr_done), .count(cbr_cnt)
    );

    dls_cbr_gen #(
        .CSR_CYC(CSR_CYC), .CHR_CYC(CHR_CYC),
        .RAS_CYC(RAS_CYC), .RP_CYC(RP_CYC)
    ) u_cbr (
        .clk(clk), .rst_n(rst_n), .run(cbr_run),
        .ras_n(cbr_ras_n), .cas_n(cbr_cas_n), .done(cbr_done)
    );

    // Which count ends the current refresh sequence
    always_comb begin
        cbr_target = (state == ST_WAKE) ? CW'(WAKE_CYC - 1) : CW'(BURST_CYC - 1);
        cnt_last   = (cbr_cnt == cbr_target);
        cbr_run    = ((state == ST_WAKE) || (state == ST_BURST)) &&
                     !(cbr_done && cnt_last);
    end

    // Next state and timer loads of the lifecycle
    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        cnt_clr  = 1'b0;
        case (state)
            ST_INIT: begin
                state_nx = ST_PAUSE;
                tmr_load = 1'b1;
                tmr_val  = TW'(PAUSE_CYC - 1);
            end
            ST_PAUSE: if (tmr_exp) begin
                state_nx = ST_WAKE;
                cnt_clr  = 1'b1;
            end
            ST_WAKE: if (cbr_done && cnt_last) state_nx = ST_READY;
            ST_READY: if (sleep_req) begin
                state_nx = ST_SR_SETUP;
                tmr_load = 1'b1;
                tmr_val  = TW'(CSR_CYC - 1);
            end
            ST_SR_SETUP: if (tmr_exp) begin
                state_nx = ST_SR_HOLD;
                tmr_load = 1'b1;
                tmr_val  = TW'(HOLD_CYC - 1);
            end
            ST_SR_HOLD: if (tmr_exp) begin
                if (sleep_req) state_nx = ST_SR_STAY;
                else begin
                    state_nx = ST_SR_EXIT;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(RP_CYC - 1);
                end
            end
            ST_SR_STAY: if (!sleep_req) begin
                state_nx = ST_SR_EXIT;
                tmr_load = 1'b1;
                tmr_val  = TW'(RP_CYC - 1);
            end
            ST_SR_EXIT: if (tmr_exp) begin
                state_nx = ST_BURST;
                cnt_clr  = 1'b1;
            end
            ST_BURST: if (cbr_done && cnt_last) state_nx = ST_READY;
            default: state_nx = ST_INIT;
        endcase
    end

    // State register, back to the start on reset
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_INIT;
        else        state <= state_nx;
    end

    // Strobe and handshake decode
    always_comb begin
        sr_cas_low = (state == ST_SR_SETUP) || (state == ST_SR_HOLD) ||
                     (state == ST_SR_STAY);
        sr_ras_low = (state == ST_SR_HOLD) || (state == ST_SR_STAY);
        ras_n      = cbr_ras_n && !sr_ras_low;
        cas_line   = cbr_cas_n && !sr_cas_low;
        ready      = (state == ST_READY);
        own        = !ready;
        sleep_ack  = (state == ST_SR_STAY);
        we_n       = 1'b1;
    end

    // One column strobe per byte lane, all moved together
    for (genvar g = 0; g < CAS_W; g++) begin : g_lane
        assign cas_n[g] = cas_line;
    end

    // Strobes quiet throughout the power-up pause
    p_pause_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAUSE) |-> ras_n && (&cas_n));
    // Row strobe only falls with every column strobe low
    p_cbr_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (cas_n == '0));
    // Acknowledge only while the memory is held in self refresh
    p_ack_strobes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_ack |-> !ras_n && (cas_n == '0));
    // Ready and acknowledge are exclusive; controller owns idle strobes
    p_ready_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !sleep_ack && ras_n && (&cas_n));
    // Acceptance of a request drops ready on the next edge
    p_ready_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ready && sleep_req |=> !ready);
    // Acknowledge is withdrawn only after the request was
    p_ack_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleep_ack) |-> !$past(sleep_req));
    // Exit precharge keeps the row strobe high
    p_exit_precharge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SR_EXIT) |-> ras_n);
endmodule

// File: tb/dram_lifecycle_seq_tb.sv
module dram_lifecycle_seq_tb;
    localparam int PAUSE = 100;
    localparam int WAKE  = 8;
    localparam int HOLD  = 50;
    localparam int BURST = 16;
    localparam int CSR   = 1;
    localparam int CHR   = 2;
    localparam int RASW  = 10;
    localparam int RP    = 6;

    // Sleep scenarios: cycles sleep_req is held, and whether an ack is due
    localparam int SCN_N = 4;
    localparam int SCN_LEN [SCN_N] = '{200, 20, 90, 300};
    localparam bit SCN_ACK [SCN_N] = '{1'b1, 1'b0, 1'b1, 1'b1};

    logic       clk = 1'b0;
    logic       rst_n, sleep_req;
    logic       sleep_ack, ready, own, ras_n, we_n;
    logic [1:0] cas_n;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dram_lifecycle_seq #(
        .CAS_W(2), .PAUSE_CYC(PAUSE), .WAKE_CYC(WAKE), .HOLD_CYC(HOLD),
        .BURST_CYC(BURST), .CSR_CYC(CSR), .CHR_CYC(CHR),
        .RAS_CYC(RASW), .RP_CYC(RP)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req),
        .sleep_ack(sleep_ack), .ready(ready), .own(own),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Port monitor, sampled on the falling edge
    int since, falls, lowrun, highrun, last_low, high_at_fall, ack_low;
    bit fell_ev, rose_ev, ack_rise_ev, any_ack, prev_ras, prev_ack;
    int mon_fail = 0;

    always @(negedge clk) begin
        fell_ev = 0; rose_ev = 0; ack_rise_ev = 0;
        if (!rst_n) begin
            since = 0; falls = 0; lowrun = 0; highrun = 0;
            prev_ras = 1; prev_ack = 0; any_ack = 0;
        end else begin
            since++;
            if (prev_ras && !ras_n) begin
                fell_ev = 1; falls++; high_at_fall = highrun;
                if (cas_n != 2'b00) begin
                    mon_fail++;
                    $display("FAIL R3 cas_n at ras fall actual=%0d expected=0", cas_n);
                end
            end
            if (!prev_ras && ras_n) begin
                rose_ev = 1; last_low = lowrun;
            end
            if (!ras_n) begin lowrun++; highrun = 0; end
            else begin highrun++; lowrun = 0; end
            if (sleep_ack && !prev_ack) begin
                ack_rise_ev = 1; ack_low = lowrun; any_ack = 1;
            end
            if (we_n !== 1'b1) begin
                mon_fail++; $display("FAIL R10 we_n actual=%0d expected=1", we_n);
            end
            if (own !== !ready) begin
                mon_fail++; $display("FAIL R6 own actual=%0d expected=%0d", own, !ready);
            end
            if (ready && sleep_ack) begin
                mon_fail++; $display("FAIL R6 ready with ack actual=1 expected=0");
            end
            prev_ras = ras_n;
            prev_ack = sleep_ack;
        end
    end

    // Wait for ready after a reset, measuring the wake-up
    task automatic wait_wake(output int first_fall, output int bad_w, output bit tmo);
        first_fall = -1; bad_w = 0; tmo = 1;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk); #1;
            if (fell_ev && first_fall < 0) first_fall = since;
            if (rose_ev && last_low != RASW) bad_w++;
            if (ready) begin tmo = 0; break; end
        end
    endtask

    task automatic check_reset_state(input string tag);
        check(ready == 0 && sleep_ack == 0 && own == 1, {tag, " R1 handshake"},
              {ready, sleep_ack, own}, 3'b001);
        check(ras_n == 1 && cas_n == 2'b11 && we_n == 1, {tag, " R1 strobes"},
              {ras_n, cas_n, we_n}, 4'b1111);
    endtask

    // One sleep entry/exit scenario
    task automatic run_sleep(input int len, input bit exp_ack, input int idx);
        int  start, ackl, hexit, bad, sleep_low;
        bit  seen, tmo;
        start = falls; ackl = -1; hexit = -1; bad = 0; sleep_low = -1;
        seen = 0; tmo = 1;
        sleep_req = 1;
        @(negedge clk); #1;
        check(ready == 0, $sformatf("R6 ready drop scn%0d", idx), ready, 0);
        for (int i = 1; i < 5000; i++) begin
            if (i == len) sleep_req = 0;
            if (ack_rise_ev) begin seen = 1; ackl = ack_low; end
            if (fell_ev && falls - start == 2) hexit = high_at_fall;
            if (rose_ev && falls - start == 1) sleep_low = last_low;
            if (rose_ev && falls - start >= 2 && last_low != RASW) bad++;
            if (ready && i > len) begin tmo = 0; break; end
            @(negedge clk); #1;
        end
        sleep_req = 0;
        check(!tmo, $sformatf("R8 ready returns scn%0d", idx), tmo, 0);
        check(seen == exp_ack, $sformatf("R5 R9 ack seen scn%0d", idx), seen, exp_ack);
        if (exp_ack)
            check(ackl == HOLD + 1, $sformatf("R5 ack after hold scn%0d", idx), ackl, HOLD + 1);
        check(sleep_low >= HOLD, $sformatf("R9 hold width scn%0d", idx), sleep_low, HOLD);
        check(hexit >= RP, $sformatf("R7 exit precharge scn%0d", idx), hexit, RP);
        check(falls - start == 1 + BURST, $sformatf("R8 burst count scn%0d", idx),
              falls - start - 1, BURST);
        check(bad == 0, $sformatf("R11 burst widths scn%0d", idx), bad, 0);
    endtask

    initial begin
        int ff, bw, st;
        bit tmo;
        rst_n = 0; sleep_req = 0;
        repeat (5) @(negedge clk);
        #1 check_reset_state("initial");

        // R4: request during the pause is ignored
        @(negedge clk); rst_n = 1; sleep_req = 1;
        repeat (30) @(negedge clk);
        #1 check(sleep_ack == 0 && ready == 0, "R4 no ack in pause", sleep_ack, 0);
        sleep_req = 0;
        wait_wake(ff, bw, tmo);
        check(!tmo, "R3 ready after wake", tmo, 0);
        check(ff >= PAUSE, "R2 pause length", ff, PAUSE);
        check(falls == WAKE, "R3 wake cycles", falls, WAKE);
        check(bw == 0, "R11 wake widths", bw, 0);
        check(!any_ack, "R4 no ack during power-up", any_ack, 0);

        // Scenario table
        for (int k = 0; k < SCN_N; k++) begin
            repeat (3) @(negedge clk);
            run_sleep(SCN_LEN[k], SCN_ACK[k], k);
        end

        // Directed: reset in the middle of an exit burst restarts wake-up
        repeat (2) @(negedge clk);
        sleep_req = 1;
        for (int i = 0; i < 200 && !sleep_ack; i++) begin @(negedge clk); #1; end
        sleep_req = 0;
        st = falls;
        for (int i = 0; i < 500 && falls - st < 4; i++) begin @(negedge clk); #1; end
        rst_n = 0;
        @(negedge clk); @(negedge clk); #1;
        check_reset_state("mid-burst");
        rst_n = 1;
        wait_wake(ff, bw, tmo);
        check(!tmo && falls == WAKE, "R1 R3 wake repeated after reset", falls, WAKE);
        check(ff >= PAUSE, "R2 pause after re-reset", ff, PAUSE);

        check(mon_fail == 0, "R3 R6 R10 port monitor", mon_fail, 0);
        errors += mon_fail;
        checks += mon_fail;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule